// File: doc/BRIEF.md
# Grid Front-End Load and Start Sequencer

This block sequences the start of a convolution pass on a grid of ROWS x COLS processing elements. The default grid is 8 x 8. While `en` is high, two saturating counters track how long the pass has been running. The first counter measures the input-fill phase. During that phase one input word per clock enters a shift buffer of COLS words, and every element of a row reads from that shared buffer. The second counter walks a one-hot weight-load strobe across all ROWS x COLS elements, one element per clock, so that each element captures its filter weights exactly once.

Each counter raises a ready flag when its phase ends. Once both flags are up, the block emits a single start pulse and switches into compute mode. In compute mode the input buffer advances only once every STEP clocks (default 16), which matches the accumulation length of the elements. Dropping `en` clears the counters, the flags, the strobes and the rate divider, so the next rise of `en` begins a fresh pass.

Top module: `arr_load_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero, including all words of `buf_out`.
- R2: Count the clock edges at which `en` is sampled high as k = 1, 2, .... At each edge k <= COLS, the buffer shifts by one word. `din` enters word 0, which is `buf_out[DW-1:0]`, and word i moves to word i+1.
- R3: `in_rdy` is high from edge k = COLS onward, as long as `en` stays high.
- R4: `w_rdy` is high from edge k = ROWS*COLS onward, as long as `en` stays high.
- R5: After edge k, for 1 <= k <= ROWS*COLS, `wload` equals 1 << (k-1). At all other times `wload` is zero, so the strobe is at most one-hot.
- R6: `start` is high for exactly one cycle, after edge k = ROWS*COLS+1, which is the first edge at which both ready flags are seen high. It pulses once per enable period.
- R7: `slow` is high from edge k = ROWS*COLS+1 onward and marks the once-per-STEP shift rate.
- R8: At edges COLS < k <= ROWS*COLS+1 the buffer holds its contents. After that it shifts only at the edges where (k - ROWS*COLS - 1) is a positive multiple of STEP.
- R9: An edge with `en` low clears `in_rdy`, `w_rdy`, `start`, `slow` and `wload`, and restarts both counts and the divider. The buffer keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | High for the whole convolution pass |
| din | input | DW | Input data word |
| wload | output | ROWS*COLS | One-hot weight-load strobe, one bit per element |
| buf_out | output | COLS*DW | Row-shared input shift buffer, word 0 newest |
| in_rdy | output | 1 | Input buffer filled |
| w_rdy | output | 1 | All weight strobes issued |
| start | output | 1 | Single-cycle compute start |
| slow | output | 1 | Compute mode, buffer advances once per STEP clocks |

## Verification
Two events can fall on the same edge, and the bench aims at both. The first is the last weight strobe, which appears together with the rise of `w_rdy`. The second is a compute-mode buffer advance that lands on the very edge where `en` drops. The bench runs a small grid (2 x 3, STEP 4) and removes `en` exactly on an edge where a slow shift is due. It then judges that the buffer was not advanced and that every flag, strobe and the start were cleared. A second full pass with different data checks that the counters and the divider restart from zero. A per-edge model derived from the requirements predicts every output on every cycle.

// File: rtl/arr_seq_pkg.sv
package arr_seq_pkg;
  // bits needed to hold values 0..lim
  function automatic int cnt_bits(input int lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/arr_phase_ctr.sv
module arr_phase_ctr
  import arr_seq_pkg::*;
#(
  parameter int LIMIT = 8,
  localparam int W = cnt_bits(LIMIT)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         done
);
  // Saturating phase counter; done rises at the edge where cnt reaches LIMIT.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (cnt != W'(LIMIT)) begin
      cnt <= cnt + 1'b1;
      if (cnt == W'(LIMIT - 1)) done <= 1'b1;
    end
  end

  // R3 / R4: once set, the flag holds while run stays high
  assert_done_holds_R3: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && $past(done) |-> done);

  // R4: counter never passes its limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(LIMIT));
endmodule

// File: rtl/arr_in_buf.sv
module arr_in_buf #(
  parameter int WORDS = 8,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic [DW-1:0]       din,
  output logic [WORDS*DW-1:0] q
);
  logic [WORDS-1:0][DW-1:0] w;

  always_ff @(posedge clk) begin
    if (rst) w[0] <= '0;
    else if (adv) w[0] <= din;
  end

  for (genvar i = 1; i < WORDS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) w[i] <= '0;
      else if (adv) w[i] <= w[i-1];
    end
  end

  assign q = w;

  // R8: contents move only on an advance
  assert_hold_no_adv_R8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));
endmodule

// File: rtl/arr_rate_div.sv
module arr_rate_div
  import arr_seq_pkg::*;
#(
  parameter int STEP = 16,
  localparam int DV_W = cnt_bits(STEP - 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [DV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (rst || !run) div <= '0;
    else if (div == DV_W'(STEP - 1)) div <= '0;
    else div <= div + 1'b1;
  end

  assign tick = run && (div == DV_W'(STEP - 1));

  // R8: two ticks never arrive on adjacent edges
  assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/arr_load_seq.sv
module arr_load_seq
  import arr_seq_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  parameter int STEP = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [DW-1:0]         din,
  output logic [ROWS*COLS-1:0]  wload,
  output logic [COLS*DW-1:0]    buf_out,
  output logic                  in_rdy,
  output logic                  w_rdy,
  output logic                  start,
  output logic                  slow
);
  localparam int NPE  = ROWS * COLS;
  localparam int IC_W = cnt_bits(COLS);
  localparam int WC_W = cnt_bits(NPE);

  logic [IC_W-1:0] icnt;
  logic [WC_W-1:0] wcnt;
  logic            tick;
  logic            adv;
  logic [NPE-1:0]  wsel;

  // input-fill phase: COLS edges
  arr_phase_ctr #(.LIMIT(COLS)) u_in_ctr (
    .clk(clk), .rst(rst), .run(en), .cnt(icnt), .done(in_rdy)
  );

  // weight-load phase: one element per edge over the whole grid
  arr_phase_ctr #(.LIMIT(NPE)) u_w_ctr (
    .clk(clk), .rst(rst), .run(en), .cnt(wcnt), .done(w_rdy)
  );

  arr_rate_div #(.STEP(STEP)) u_div (
    .clk(clk), .rst(rst), .run(slow), .tick(tick)
  );

  // fast fill until input ready, then hold, then one advance per STEP
  assign adv = en && (!in_rdy || tick);

  arr_in_buf #(.WORDS(COLS), .DW(DW)) u_buf (
    .clk(clk), .rst(rst), .adv(adv), .din(din), .q(buf_out)
  );

  for (genvar i = 0; i < NPE; i++) begin : g_wsel
    assign wsel[i] = (wcnt == WC_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wload <= '0;
      start <= 1'b0;
      slow  <= 1'b0;
    end else begin
      wload <= wsel;
      start <= in_rdy && w_rdy && !slow;
      slow  <= in_rdy && w_rdy;
    end
  end

  // R5: strobe is at most one-hot
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wload));

  // R6: start lasts one cycle
  assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R7: compute mode only with both phases complete
  assert_slow_needs_flags_R7: assert property (@(posedge clk) disable iff (rst)
    slow |-> (in_rdy && w_rdy));

  // R4: weights finish no earlier than input fill
  assert_order_R4: assert property (@(posedge clk) disable iff (rst)
    w_rdy |-> in_rdy);

  // R9: an edge with enable low clears the control outputs
  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!in_rdy && !w_rdy && !slow && !start && wload == '0));
endmodule

// File: tb/sim_arr_load_seq.sv
module sim_arr_load_seq;
  localparam int ROWS = 2;
  localparam int COLS = 3;
  localparam int DW   = 8;
  localparam int STEP = 4;
  localparam int NPE  = ROWS * COLS;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 en  = 1'b0;
  logic [DW-1:0]        din = '0;
  logic [NPE-1:0]       wload;
  logic [COLS*DW-1:0]   buf_out;
  logic                 in_rdy, w_rdy, start, slow;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int mb [COLS];

  always #10 clk = ~clk;

  arr_load_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .en(en), .din(din), .wload(wload),
    .buf_out(buf_out), .in_rdy(in_rdy), .w_rdy(w_rdy),
    .start(start), .slow(slow)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (k=%0d)", tag, what, act, exp, k);
    end
  endtask

  // one clock with given enable and data; model then compare at negedge
  task automatic tick(input logic e, input logic [DW-1:0] d);
    bit sh;
    string bt;
    en  = e;
    din = d;
    @(posedge clk);
    sh = 1'b0;
    if (!e) k = 0;
    else begin
      k++;
      sh = (k <= COLS) || (k > NPE + 1 && ((k - NPE - 1) % STEP) == 0);
      if (sh) begin
        for (int i = COLS - 1; i > 0; i--) mb[i] = mb[i-1];
        mb[0] = int'(d);
      end
    end
    @(negedge clk);
    bt = !e ? "R9" : (k <= COLS ? "R2" : "R8");
    for (int i = 0; i < COLS; i++)
      chk(bt, $sformatf("word%0d", i), 64'(buf_out[i*DW +: DW]), 64'(mb[i]));
    chk(e ? "R3" : "R9", "in_rdy", 64'(in_rdy), 64'(e && k >= COLS));
    chk(e ? "R4" : "R9", "w_rdy",  64'(w_rdy),  64'(e && k >= NPE));
    chk(e ? "R5" : "R9", "wload",  64'(wload),
        (e && k >= 1 && k <= NPE) ? (64'd1 << (k - 1)) : 64'd0);
    chk(e ? "R6" : "R9", "start",  64'(start),  64'(e && k == NPE + 1));
    chk(e ? "R7" : "R9", "slow",   64'(slow),   64'(e && k >= NPE + 1));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < COLS; i++) mb[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "buf_out", 64'(buf_out), 64'd0);
    chk("R1", "wload", 64'(wload), 64'd0);
    chk("R1", "flags", 64'({in_rdy, w_rdy, start, slow}), 64'd0);
    rst = 1'b0;
    tick(1'b0, 8'h55);
    // pass 1: fill, hold, start, slow shifts at k = 11, 15, 19
    for (int i = 0; i < 22; i++) tick(1'b1, DW'(8'h10 + i));
    // R9: enable drops on the edge where k = 23 would have shifted
    tick(1'b0, 8'hEE);
    for (int i = 0; i < 3; i++) tick(1'b0, DW'(8'hC0 + i));
    // pass 2: counters and divider restart from zero
    for (int i = 0; i < 26; i++) tick(1'b1, DW'(8'hA0 ^ (i * 7)));
    tick(1'b0, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule